// File: doc/BRIEF.md
# Time-Interleaved Homogeneous NFA Matcher

This block runs a homogeneous nondeterministic automaton over several independent byte streams that share one datapath. Every state is entered only on its own configured set of symbols. Each incoming 8-bit symbol picks a row in a symbol table, and that row marks the states that may be entered on that symbol. The engine routes the previous active vector through a transition network and ANDs the result with that row. This gives the new active vector. A stream reports a hit when the new vector overlaps the configured accept set.

The transition network has two registered phases. A global phase takes a few export states from each tile and ORs them into a small set of cross-tile lines. A local phase then maps each tile's own states, together with those cross-tile lines, onto the follow vector. The direct path from the active vector to the local phase goes through a register, so every active-to-follow path takes exactly two cycles. Each stream (context slot) keeps its own active vector. The upstream source interleaves slots so that the same slot never appears in two consecutive cycles. The clock period is then set by one switching phase rather than by both phases in series.

Configuration goes through a write port while no symbols are in flight. A start flag on a symbol makes that symbol begin a fresh match from the configured start set.

Top module: `nfa_tdm_engine`

## Requirements
- R1: While reset is applied, and for the first cycles after it, acc_valid_o and acc_hit_o are 0. Reset clears every slot's active vector, so symbols fed before any start vector is loaded never produce a hit.
- R2: A cycle with cfg_we_i=1 writes one configuration item chosen by cfg_kind_i: 0 = symbol row (cfg_addr_i is the symbol, cfg_data_i bit k allows state k), 1 = global line row, 2 = local row of state cfg_addr_i, 3 = accept vector, 4 = start vector.
- R3: For a taken symbol, the new active vector is the follow vector ANDed with the symbol row selected by the symbol value.
- R4: There are 4 tiles of 8 states, and state k lies in tile k/8. Each tile exports its states with in-tile index 0 and 1, and exported state t*8+e drives global input t*2+e. Global line i is the OR of (global row i AND global inputs). In the local row of state j, bits 0..7 select the states of j's own tile by in-tile index, and bits 8..15 select global lines 0..7. Follow bit j is the OR of (local row j AND that 16-bit vector).
- R5: acc_hit_o is 1 exactly when the new active vector of the reported symbol shares a set bit with the accept vector, and it is 0 whenever acc_valid_o is 0.
- R6: A symbol taken at a clock edge is reported on acc_valid_o and acc_slot_o after the second following edge, with its own slot tag. No other cycle has acc_valid_o high.
- R7: Interleaved slots are independent. The results of one slot never depend on the symbols of another.
- R8: A symbol with sym_start_i=1 uses the start vector as its previous active vector in place of its slot's stored vector.
- R9: Writing the start vector (kind 4) also loads that vector into every slot's active vector.
- R10: A symbol presented while cfg_we_i=1 is ignored. It produces no output and leaves the slot's active vector unchanged.
- R11: A slot may be fed at most every second cycle. A single stream fed with one idle cycle between its symbols is processed correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| sym_valid_i | input | 1 | A symbol is presented this cycle |
| sym_slot_i | input | 1 | Context slot of the presented symbol |
| sym_start_i | input | 1 | Symbol begins a new match from the start vector |
| sym_i | input | 8 | Symbol value |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_kind_i | input | 3 | Configuration item kind (0..4) |
| cfg_addr_i | input | 8 | Symbol, global line or state index of the item |
| cfg_data_i | input | 32 | Configuration data |
| acc_valid_o | output | 1 | A symbol result is reported |
| acc_slot_o | output | 1 | Slot of the reported result |
| acc_hit_o | output | 1 | The reported symbol completed an accepted match |

## Verification
The hardest case to reach is a cross-tile step in one slot while the other slot's symbol sits in the other pipeline phase. A wrong slot index or a missing balance register only shows up when both slots carry live, differing state in adjacent cycles. The bench builds an automaton whose accepted word has to pass through two global lines across three tiles, and a second word that stays inside one tile. It then alternates the slots every cycle with streams that match, break and restart at different points. A reference model checks every reported hit and slot tag in its exact cycle. Separate scenarios drop a symbol under a configuration write and feed one stream with idle gaps.

// File: rtl/nfa_tdm_pkg.sv
package nfa_tdm_pkg;

  // Configuration item selector carried on cfg_kind_i
  typedef enum logic [2:0] {
    CFG_MATCH  = 3'd0,
    CFG_GLOBAL = 3'd1,
    CFG_LOCAL  = 3'd2,
    CFG_ACCEPT = 3'd3,
    CFG_START  = 3'd4
  } cfg_kind_e;

endpackage

// File: rtl/nfa_reset_sync.sv
module nfa_reset_sync (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_no
);

  logic [1:0] sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= 2'b00;
    end else begin
      sync_q <= {sync_q[0], 1'b1};
    end
  end

  assign rst_no = sync_q[1];

endmodule

// File: rtl/nfa_symbol_table.sv
module nfa_symbol_table #(
  parameter int unsigned SYM_W = 8,
  parameter int unsigned ROW_W = 32
) (
  input  logic             clk_i,
  input  logic             wr_en_i,
  input  logic [SYM_W-1:0] wr_addr_i,
  input  logic [ROW_W-1:0] wr_data_i,
  input  logic             rd_en_i,
  input  logic [SYM_W-1:0] rd_addr_i,
  output logic [ROW_W-1:0] rd_row_o
);

  localparam int unsigned DEPTH = 1 << SYM_W;

  logic [ROW_W-1:0] mem_q [DEPTH];
  logic [ROW_W-1:0] rd_row_q;

  // configuration storage, written only while the engine is idle
  always_ff @(posedge clk_i) begin
    if (wr_en_i) begin
      mem_q[wr_addr_i] <= wr_data_i;
    end
  end

  // registered lookup: forms the symbol-match half of the first pipeline phase
  always_ff @(posedge clk_i) begin
    if (rd_en_i) begin
      rd_row_q <= mem_q[rd_addr_i];
    end
  end

  assign rd_row_o = rd_row_q;

endmodule

// File: rtl/nfa_global_switch.sv
module nfa_global_switch #(
  parameter int unsigned N_STATES = 32,
  parameter int unsigned N_TILES  = 4,
  parameter int unsigned N_EXPORT = 2,
  parameter int unsigned N_GLOBAL = 8,
  parameter int unsigned ADDR_W   = 8
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          cfg_en_i,
  input  logic [ADDR_W-1:0]             cfg_addr_i,
  input  logic [N_TILES*N_EXPORT-1:0]   cfg_row_i,
  input  logic [N_STATES-1:0]           active_i,
  output logic [N_GLOBAL-1:0]           gout_o
);

  localparam int unsigned TILE_W = N_STATES / N_TILES;
  localparam int unsigned GIN_W  = N_TILES * N_EXPORT;

  logic [GIN_W-1:0] gin;
  logic [GIN_W-1:0] row_q [N_GLOBAL];
  logic [GIN_W-1:0] row_d [N_GLOBAL];

  // gather the exported low-index states of every tile
  for (genvar t = 0; t < N_TILES; t++) begin : g_tile
    for (genvar e = 0; e < N_EXPORT; e++) begin : g_exp
      assign gin[t*N_EXPORT+e] = active_i[t*TILE_W+e];
    end
  end

  always_comb begin
    for (int i = 0; i < N_GLOBAL; i++) begin
      row_d[i] = row_q[i];
      if (cfg_en_i && (cfg_addr_i == ADDR_W'(i))) begin
        row_d[i] = cfg_row_i;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < N_GLOBAL; i++) begin
        row_q[i] <= '0;
      end
    end else begin
      for (int i = 0; i < N_GLOBAL; i++) begin
        row_q[i] <= row_d[i];
      end
    end
  end

  for (genvar i = 0; i < N_GLOBAL; i++) begin : g_line
    assign gout_o[i] = |(row_q[i] & gin);
  end

endmodule

// File: rtl/nfa_local_switch.sv
module nfa_local_switch #(
  parameter int unsigned N_STATES = 32,
  parameter int unsigned N_TILES  = 4,
  parameter int unsigned N_GLOBAL = 8,
  parameter int unsigned ADDR_W   = 8
) (
  input  logic                                    clk_i,
  input  logic                                    rst_ni,
  input  logic                                    cfg_en_i,
  input  logic [ADDR_W-1:0]                       cfg_addr_i,
  input  logic [N_STATES/N_TILES+N_GLOBAL-1:0]    cfg_row_i,
  input  logic [N_STATES-1:0]                     abuf_i,
  input  logic [N_GLOBAL-1:0]                     gout_i,
  output logic [N_STATES-1:0]                     follow_o
);

  localparam int unsigned TILE_W = N_STATES / N_TILES;
  localparam int unsigned LOC_W  = TILE_W + N_GLOBAL;

  logic [LOC_W-1:0] row_q [N_STATES];
  logic [LOC_W-1:0] row_d [N_STATES];

  always_comb begin
    for (int j = 0; j < N_STATES; j++) begin
      row_d[j] = row_q[j];
      if (cfg_en_i && (cfg_addr_i == ADDR_W'(j))) begin
        row_d[j] = cfg_row_i;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int j = 0; j < N_STATES; j++) begin
        row_q[j] <= '0;
      end
    end else begin
      for (int j = 0; j < N_STATES; j++) begin
        row_q[j] <= row_d[j];
      end
    end
  end

  // each state sees its own tile plus all cross-tile lines (the global vector)
  for (genvar j = 0; j < N_STATES; j++) begin : g_state
    localparam int unsigned TBASE = (j / TILE_W) * TILE_W;
    logic [LOC_W-1:0] gvec;
    assign gvec        = {gout_i, abuf_i[TBASE +: TILE_W]};
    assign follow_o[j] = |(row_q[j] & gvec);
  end

endmodule

// File: rtl/nfa_tdm_engine.sv
module nfa_tdm_engine #(
  parameter int unsigned SYM_W    = 8,
  parameter int unsigned N_STATES = 32,
  parameter int unsigned N_TILES  = 4,
  parameter int unsigned N_EXPORT = 2,
  parameter int unsigned N_GLOBAL = 8,
  parameter int unsigned N_SLOTS  = 2
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       sym_valid_i,
  input  logic [$clog2(N_SLOTS)-1:0] sym_slot_i,
  input  logic                       sym_start_i,
  input  logic [SYM_W-1:0]           sym_i,
  input  logic                       cfg_we_i,
  input  logic [2:0]                 cfg_kind_i,
  input  logic [SYM_W-1:0]           cfg_addr_i,
  input  logic [N_STATES-1:0]        cfg_data_i,
  output logic                       acc_valid_o,
  output logic [$clog2(N_SLOTS)-1:0] acc_slot_o,
  output logic                       acc_hit_o
);

  import nfa_tdm_pkg::*;

  localparam int unsigned SLOT_W = $clog2(N_SLOTS);
  localparam int unsigned TILE_W = N_STATES / N_TILES;
  localparam int unsigned GIN_W  = N_TILES * N_EXPORT;
  localparam int unsigned LOC_W  = TILE_W + N_GLOBAL;

  // ---------------- reset and configuration decode ----------------
  logic      rst_n;
  cfg_kind_e cfg_kind;
  logic      wr_match, wr_global, wr_local, wr_accept, wr_start;
  logic      take;

  nfa_reset_sync u_rst_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .rst_no (rst_n)
  );

  assign cfg_kind  = cfg_kind_e'(cfg_kind_i);
  assign wr_match  = cfg_we_i && (cfg_kind == CFG_MATCH);
  assign wr_global = cfg_we_i && (cfg_kind == CFG_GLOBAL);
  assign wr_local  = cfg_we_i && (cfg_kind == CFG_LOCAL);
  assign wr_accept = cfg_we_i && (cfg_kind == CFG_ACCEPT);
  assign wr_start  = cfg_we_i && (cfg_kind == CFG_START);
  // symbols are dropped while configuration is being written
  assign take      = sym_valid_i && !cfg_we_i;

  // ---------------- accept and start vectors ----------------
  logic [N_STATES-1:0] accept_q, accept_d;
  logic [N_STATES-1:0] start_q,  start_d;

  always_comb begin
    accept_d = wr_accept ? cfg_data_i : accept_q;
    start_d  = wr_start  ? cfg_data_i : start_q;
  end

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) begin
      accept_q <= '0;
      start_q  <= '0;
    end else begin
      accept_q <= accept_d;
      start_q  <= start_d;
    end
  end

  // ---------------- per-slot active vectors ----------------
  logic [N_STATES-1:0] ctx_q [N_SLOTS];
  logic [N_STATES-1:0] ctx_d [N_SLOTS];
  logic [N_STATES-1:0] prev_act;
  logic [N_STATES-1:0] next_act;

  logic                s1_valid_q;
  logic [SLOT_W-1:0]   s1_slot_q;
  logic [N_GLOBAL-1:0] s1_gout_q;
  logic [N_STATES-1:0] s1_abuf_q;

  always_comb begin
    prev_act = '0;
    for (int k = 0; k < N_SLOTS; k++) begin
      if (sym_slot_i == SLOT_W'(k)) begin
        prev_act = ctx_q[k];
      end
    end
    if (sym_start_i) begin
      prev_act = start_q;
    end
  end

  // ---------------- phase 1: symbol lookup and global switch ----------------
  logic [N_GLOBAL-1:0] gout;
  logic [N_STATES-1:0] match_row;

  nfa_symbol_table #(
    .SYM_W (SYM_W),
    .ROW_W (N_STATES)
  ) u_sym_table (
    .clk_i     (clk_i),
    .wr_en_i   (wr_match),
    .wr_addr_i (cfg_addr_i),
    .wr_data_i (cfg_data_i),
    .rd_en_i   (take),
    .rd_addr_i (sym_i),
    .rd_row_o  (match_row)
  );

  nfa_global_switch #(
    .N_STATES (N_STATES),
    .N_TILES  (N_TILES),
    .N_EXPORT (N_EXPORT),
    .N_GLOBAL (N_GLOBAL),
    .ADDR_W   (SYM_W)
  ) u_global (
    .clk_i      (clk_i),
    .rst_ni     (rst_n),
    .cfg_en_i   (wr_global),
    .cfg_addr_i (cfg_addr_i),
    .cfg_row_i  (cfg_data_i[GIN_W-1:0]),
    .active_i   (prev_act),
    .gout_o     (gout)
  );

  // phase-1 register: global lines plus the balancing buffer on the direct path
  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) begin
      s1_valid_q <= 1'b0;
      s1_slot_q  <= '0;
      s1_gout_q  <= '0;
      s1_abuf_q  <= '0;
    end else begin
      s1_valid_q <= take;
      if (take) begin
        s1_slot_q <= sym_slot_i;
        s1_gout_q <= gout;
        s1_abuf_q <= prev_act;
      end
    end
  end

  // ---------------- phase 2: local switch and state update ----------------
  logic [N_STATES-1:0] follow;
  logic                stage_hit;

  nfa_local_switch #(
    .N_STATES (N_STATES),
    .N_TILES  (N_TILES),
    .N_GLOBAL (N_GLOBAL),
    .ADDR_W   (SYM_W)
  ) u_local (
    .clk_i      (clk_i),
    .rst_ni     (rst_n),
    .cfg_en_i   (wr_local),
    .cfg_addr_i (cfg_addr_i),
    .cfg_row_i  (cfg_data_i[LOC_W-1:0]),
    .abuf_i     (s1_abuf_q),
    .gout_i     (s1_gout_q),
    .follow_o   (follow)
  );

  assign next_act  = follow & match_row;
  assign stage_hit = |(next_act & accept_q);

  always_comb begin
    for (int k = 0; k < N_SLOTS; k++) begin
      ctx_d[k] = ctx_q[k];
      if (wr_start) begin
        ctx_d[k] = cfg_data_i;
      end else if (s1_valid_q && (s1_slot_q == SLOT_W'(k))) begin
        ctx_d[k] = next_act;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < N_SLOTS; k++) begin
        ctx_q[k] <= '0;
      end
    end else begin
      for (int k = 0; k < N_SLOTS; k++) begin
        ctx_q[k] <= ctx_d[k];
      end
    end
  end

  // ---------------- acceptance output ----------------
  logic              acc_valid_q;
  logic [SLOT_W-1:0] acc_slot_q;
  logic              acc_hit_q;

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) begin
      acc_valid_q <= 1'b0;
      acc_slot_q  <= '0;
      acc_hit_q   <= 1'b0;
    end else begin
      acc_valid_q <= s1_valid_q;
      acc_hit_q   <= s1_valid_q && stage_hit;
      if (s1_valid_q) begin
        acc_slot_q <= s1_slot_q;
      end
    end
  end

  assign acc_valid_o = acc_valid_q;
  assign acc_slot_o  = acc_slot_q;
  assign acc_hit_o   = acc_hit_q;

endmodule

// File: rtl/nfa_tdm_checker.sv
module nfa_tdm_checker #(
  parameter int unsigned SLOT_W = 1
) (
  input logic              clk_i,
  input logic              rst_n,
  input logic              sym_valid_i,
  input logic [SLOT_W-1:0] sym_slot_i,
  input logic              cfg_we_i,
  input logic              acc_valid_o,
  input logic [SLOT_W-1:0] acc_slot_o,
  input logic              acc_hit_o
);

  // cycles since reset release, saturating, so $past(...,2) never reaches into reset
  logic [1:0] age_q;

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) begin
      age_q <= 2'd0;
    end else if (age_q != 2'd2) begin
      age_q <= age_q + 2'd1;
    end
  end

  // R6: every taken symbol is reported two edges later with its own slot
  p_report_latency_r6: assert property (@(posedge clk_i) disable iff (!rst_n)
    (age_q == 2'd2 && $past(sym_valid_i && !cfg_we_i, 2))
      |-> (acc_valid_o && acc_slot_o == $past(sym_slot_i, 2)));

  // R6: no report without a taken symbol two edges earlier
  p_no_spurious_report_r6: assert property (@(posedge clk_i) disable iff (!rst_n)
    (age_q == 2'd2 && acc_valid_o) |-> $past(sym_valid_i && !cfg_we_i, 2));

  // R10: a symbol under a configuration write never produces a report
  p_cfg_drops_symbol_r10: assert property (@(posedge clk_i) disable iff (!rst_n)
    (age_q == 2'd2 && $past(cfg_we_i, 2)) |-> !acc_valid_o);

  // R5: a hit is only signalled alongside a valid report
  p_hit_needs_valid_r5: assert property (@(posedge clk_i) disable iff (!rst_n)
    !acc_valid_o |-> !acc_hit_o);

  // R11: the same slot never takes symbols in two consecutive cycles
  p_slot_spacing_r11: assert property (@(posedge clk_i) disable iff (!rst_n)
    (sym_valid_i && !cfg_we_i)
      |=> !(sym_valid_i && !cfg_we_i && sym_slot_i == $past(sym_slot_i)));

endmodule

bind nfa_tdm_engine nfa_tdm_checker #(.SLOT_W(SLOT_W)) u_checker (
  .clk_i       (clk_i),
  .rst_n       (rst_n),
  .sym_valid_i (sym_valid_i),
  .sym_slot_i  (sym_slot_i),
  .cfg_we_i    (cfg_we_i),
  .acc_valid_o (acc_valid_o),
  .acc_slot_o  (acc_slot_o),
  .acc_hit_o   (acc_hit_o)
);

// File: tb/nfa_tdm_engine_bench.sv
module nfa_tdm_engine_bench;

  localparam int CLK_PERIOD = 10;

  logic        clk;
  logic        rst_ni;
  logic        sym_valid;
  logic [0:0]  sym_slot;
  logic        sym_start;
  logic [7:0]  sym;
  logic        cfg_we;
  logic [2:0]  cfg_kind;
  logic [7:0]  cfg_addr;
  logic [31:0] cfg_data;
  logic        acc_valid;
  logic [0:0]  acc_slot;
  logic        acc_hit;

  nfa_tdm_engine u_nfa_tdm_engine (
    .clk_i       (clk),
    .rst_ni      (rst_ni),
    .sym_valid_i (sym_valid),
    .sym_slot_i  (sym_slot),
    .sym_start_i (sym_start),
    .sym_i       (sym),
    .cfg_we_i    (cfg_we),
    .cfg_kind_i  (cfg_kind),
    .cfg_addr_i  (cfg_addr),
    .cfg_data_i  (cfg_data),
    .acc_valid_o (acc_valid),
    .acc_slot_o  (acc_slot),
    .acc_hit_o   (acc_hit)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  int n_chk = 0;
  int n_err = 0;
  bit finished = 0;

  // bench copy of the configuration and of each slot's state
  logic [31:0] b_match [256];
  logic [7:0]  b_grow  [8];
  logic [15:0] b_lrow  [32];
  logic [31:0] b_acc;
  logic [31:0] b_start;
  logic [31:0] b_ctx   [2];

  // expected report pipeline (entry pushed when driven, checked two negedges later)
  logic  d1_v, d2_v;
  logic  d1_slot, d2_slot;
  logic  d1_hit, d2_hit;
  string d1_tag, d2_tag;
  string cur_tag;

  task automatic check(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  function automatic logic [31:0] golden_row(input logic [7:0] s);
    logic [31:0] r;
    r = 32'h0;
    r[7]  = 1'b1;
    r[31] = 1'b1;
    if (s == "a") r[0]  = 1'b1;
    if (s == "b") r[8]  = 1'b1;
    if (s == "c") r[16] = 1'b1;
    if (s == "x") r[24] = 1'b1;
    if (s == "y") r[25] = 1'b1;
    return r;
  endfunction

  // model from R3 and R4
  function automatic logic [31:0] model_step(input logic [31:0] prev, input logic [7:0] s);
    logic [7:0]  gin;
    logic [7:0]  gout;
    logic [31:0] fol;
    for (int t = 0; t < 4; t++)
      for (int e = 0; e < 2; e++)
        gin[t*2+e] = prev[t*8+e];
    for (int i = 0; i < 8; i++)
      gout[i] = |(b_grow[i] & gin);
    for (int j = 0; j < 32; j++)
      fol[j] = |(b_lrow[j] & {gout, prev[(j/8)*8 +: 8]});
    return fol & b_match[s];
  endfunction

  task automatic tick(input logic v, input logic sl, input logic st, input logic [7:0] s,
                      input logic we, input logic [2:0] kind, input logic [7:0] addr,
                      input logic [31:0] data);
    logic [31:0] prev;
    logic [31:0] nxt;
    logic        nv;
    logic        nhit;
    @(negedge clk);
    check(d2_tag, "acc_valid_o", 32'(acc_valid), 32'(d2_v));
    if (d2_v) begin
      check(d2_tag, "acc_slot_o", 32'(acc_slot), 32'(d2_slot));
      check(d2_tag, "acc_hit_o", 32'(acc_hit), 32'(d2_hit));
    end
    d2_v = d1_v; d2_slot = d1_slot; d2_hit = d1_hit; d2_tag = d1_tag;
    nv   = v && !we;
    nhit = 1'b0;
    if (we) begin
      case (kind)
        3'd0: b_match[addr] = data;
        3'd1: b_grow[addr[2:0]] = data[7:0];
        3'd2: b_lrow[addr[4:0]] = data[15:0];
        3'd3: b_acc = data;
        3'd4: begin b_start = data; b_ctx[0] = data; b_ctx[1] = data; end
        default: ;
      endcase
    end
    if (nv) begin
      prev      = st ? b_start : b_ctx[sl];
      nxt       = model_step(prev, s);
      b_ctx[sl] = nxt;
      nhit      = |(nxt & b_acc);
    end
    d1_v = nv; d1_slot = sl; d1_hit = nhit; d1_tag = cur_tag;
    sym_valid = v; sym_slot = sl; sym_start = st; sym = s;
    cfg_we = we; cfg_kind = kind; cfg_addr = addr; cfg_data = data;
  endtask

  task automatic send(input logic sl, input logic st, input logic [7:0] s);
    tick(1'b1, sl, st, s, 1'b0, 3'd0, 8'd0, 32'd0);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) tick(1'b0, 1'b0, 1'b0, 8'd0, 1'b0, 3'd0, 8'd0, 32'd0);
  endtask

  task automatic cfg_write(input logic [2:0] kind, input logic [7:0] addr, input logic [31:0] data);
    tick(1'b0, 1'b0, 1'b0, 8'd0, 1'b1, kind, addr, data);
  endtask

  // R1: outputs quiet during and just after reset
  task automatic t_reset;
    cur_tag = "R1";
    repeat (3) @(negedge clk);
    check("R1", "acc_valid_o in reset", 32'(acc_valid), 32'd0);
    check("R1", "acc_hit_o in reset", 32'(acc_hit), 32'd0);
    rst_ni = 1'b1;
    idle(4);
  endtask

  // R2, R4: load the automaton (start vector left for later)
  task automatic t_configure;
    cur_tag = "R2";
    for (int s = 0; s < 256; s++) cfg_write(3'd0, 8'(s), golden_row(8'(s)));
    for (int i = 0; i < 8; i++) cfg_write(3'd1, 8'(i), 32'h0);
    cfg_write(3'd1, 8'd0, 32'h01);          // global line 0 <- state 0
    cfg_write(3'd1, 8'd1, 32'h04);          // global line 1 <- state 8
    for (int j = 0; j < 32; j++) cfg_write(3'd2, 8'(j), 32'h0);
    cfg_write(3'd2, 8'd7,  32'h0080);       // state 7 self loop
    cfg_write(3'd2, 8'd0,  32'h0080);       // state 0 <- state 7
    cfg_write(3'd2, 8'd8,  32'h0100);       // state 8 <- global 0 (R4 cross tile)
    cfg_write(3'd2, 8'd16, 32'h0200);       // state 16 <- global 1
    cfg_write(3'd2, 8'd31, 32'h0080);       // state 31 self loop
    cfg_write(3'd2, 8'd24, 32'h0080);       // state 24 <- state 31
    cfg_write(3'd2, 8'd25, 32'h0001);       // state 25 <- state 24
    cfg_write(3'd3, 8'd0, 32'h0201_0000);   // accept states 16 and 25
  endtask

  // R1: cleared contexts never reach acceptance
  task automatic t_cleared;
    cur_tag = "R1";
    send(1'b0, 1'b0, "a"); send(1'b1, 1'b0, "x");
    send(1'b0, 1'b0, "b"); send(1'b1, 1'b0, "y");
    send(1'b0, 1'b0, "c"); idle(2);
  endtask

  // R9: writing the start vector seeds every slot
  task automatic t_start_load;
    cur_tag = "R9";
    cfg_write(3'd4, 8'd0, 32'h8000_0080);
    send(1'b0, 1'b0, "a"); send(1'b1, 1'b0, "x");
    send(1'b0, 1'b0, "b"); send(1'b1, 1'b0, "y");
    send(1'b0, 1'b0, "c"); idle(2);
  endtask

  // R3: symbol rows gate the follow vector
  task automatic t_symbol_match;
    cur_tag = "R3";
    send(1'b0, 1'b1, "a"); send(1'b1, 1'b1, "a");
    send(1'b0, 1'b0, "x"); send(1'b1, 1'b0, "b");
    send(1'b0, 1'b0, "c"); send(1'b1, 1'b0, "c");
    idle(2);
  endtask

  // R4, R5: cross-tile word and in-tile word, accept on both
  task automatic t_cross_tile;
    cur_tag = "R4";
    send(1'b0, 1'b1, "a"); send(1'b1, 1'b1, "x");
    send(1'b0, 1'b0, "b"); send(1'b1, 1'b0, "y");
    cur_tag = "R5";
    send(1'b0, 1'b0, "c"); send(1'b1, 1'b0, "c");
    send(1'b0, 1'b0, "c"); send(1'b1, 1'b0, "x");
    idle(2);
  endtask

  // R7: two differing streams alternating every cycle
  task automatic t_interleave;
    string w0, w1;
    cur_tag = "R7";
    w0 = "zabcabca";
    w1 = "xyxxyqxy";
    for (int i = 0; i < 8; i++) begin
      send(1'b0, (i == 0), w0[i]);
      send(1'b1, (i == 0), w1[i]);
    end
    idle(2);
  endtask

  // R8: start flag discards the slot's stored progress
  task automatic t_start_flag;
    cur_tag = "R8";
    send(1'b0, 1'b1, "a"); send(1'b1, 1'b1, "x");
    send(1'b0, 1'b0, "b"); send(1'b1, 1'b0, "q");
    send(1'b0, 1'b1, "c"); send(1'b1, 1'b1, "x");
    send(1'b0, 1'b0, "a"); send(1'b1, 1'b0, "y");
    send(1'b0, 1'b0, "b"); idle(1);
    send(1'b0, 1'b0, "c"); idle(2);
  endtask

  // R11, R6: one stream with gaps, each report exactly two edges later
  task automatic t_gap_stream;
    cur_tag = "R11";
    send(1'b0, 1'b1, "a"); idle(1);
    send(1'b0, 1'b0, "b"); idle(1);
    cur_tag = "R6";
    send(1'b0, 1'b0, "c"); idle(3);
    send(1'b1, 1'b1, "x"); idle(1);
    send(1'b1, 1'b0, "y"); idle(2);
  endtask

  // R10: symbol under a configuration write is dropped
  task automatic t_cfg_ignored;
    cur_tag = "R10";
    send(1'b0, 1'b1, "a"); send(1'b1, 1'b1, "x");
    send(1'b0, 1'b0, "b");
    tick(1'b1, 1'b0, 1'b0, "z", 1'b1, 3'd0, "z", golden_row("z"));
    send(1'b0, 1'b0, "c");   // still completes: the dropped z left slot 0 untouched
    idle(2);
    check("R10", "slot 0 accepted after dropped symbol", 32'(b_ctx[0][16]), 32'd1);
  endtask

  initial begin
    rst_ni = 1'b1;
    sym_valid = 1'b0; sym_slot = 1'b0; sym_start = 1'b0; sym = 8'd0;
    cfg_we = 1'b0; cfg_kind = 3'd0; cfg_addr = 8'd0; cfg_data = 32'd0;
    d1_v = 1'b0; d2_v = 1'b0; d1_slot = 1'b0; d2_slot = 1'b0;
    d1_hit = 1'b0; d2_hit = 1'b0; d1_tag = "R1"; d2_tag = "R1";
    b_acc = '0; b_start = '0; b_ctx[0] = '0; b_ctx[1] = '0;
    #1 rst_ni = 1'b0;
    t_reset();
    t_configure();
    t_cleared();
    t_start_load();
    t_symbol_match();
    t_cross_tile();
    t_interleave();
    t_start_flag();
    t_gap_stream();
    t_cfg_ignored();
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

endmodule